// File: doc/BRIEF.md
# Data-Processing Execute Unit with Condition Flags

This block is the arithmetic and logic stage of a 32-bit RISC core's data-processing path. It is purely combinational. It receives a first operand read from a register and a second operand that an upstream shifter has already formed, together with that shifter's carry-out. It also receives a 4-bit operation selector, a set-flags request, the index of the destination register and the current condition flags. In the same cycle it returns the result, a result write strobe, the next condition flags and a flag write strobe.

The sixteen operations fall into three groups: bitwise operations, an add family and a subtract family. The subtract family includes reversed-operand forms and forms that take a carry input. Four of the operations only compare and never write a result. When flags are requested and the result goes to register 15, which is the program counter, the unit does not update the flags. Instead it raises a strobe that tells the surrounding core to restore the saved processor mode. The core performs that restore itself.

Top module: `dp_alu`

## Requirements
- R1: The result for each selector value `op_code` is: 0 A&B, 1 A^B, 2 A-B, 3 B-A, 4 A+B, 5 A+B+C, 6 A-B-1+C, 7 B-A-1+C, 8 A&B, 9 A^B, 10 A-B, 11 A+B, 12 A|B, 13 B, 14 A&~B, 15 ~B. C is the incoming carry flag, and all arithmetic is modulo 2^32.
- R2: `result_we` is 0 for selectors 8 to 11 (op_code[3:2] = 2'b10) and 1 for every other selector.
- R3: When `set_flags` is 0, `flags_we` is 0 and `flags_out` equals `flags_in`. The flag vectors are packed as {N,Z,C,V}, with N in bit 3 and V in bit 0.
- R4: For the bitwise selectors (0, 1, 8, 9, 12, 13, 14, 15) with a flag update, C becomes `shf_carry` and V keeps its incoming value.
- R5: For the subtract selectors (2, 3, 6, 7, 10), C is 1 exactly when no borrow occurs. Selectors 3 and 7 subtract A from B. Selectors 2 and 10 use a carry input of 1. Selectors 6 and 7 use the incoming C as the carry input.
- R6: For the add selectors, C is the carry out of bit 31. Selectors 4 and 11 use a carry input of 0, and selector 5 uses the incoming C.
- R7: For the arithmetic selectors, V is 1 on signed overflow. For an add, overflow means both operands share a sign and the result's sign differs. For a subtract, it means the minuend and subtrahend differ in sign and the result's sign differs from the minuend's.
- R8: `restore_mode` is 1 exactly when `set_flags` is 1, `result_we` is 1 and `dst_idx` is 15. In that case `flags_we` is 0 and `flags_out` equals `flags_in`.
- R9: On any flag update, N equals result bit 31, and Z is 1 exactly when all 32 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand, taken from a register |
| opnd_b | input | 32 | Second operand, produced by the shifter |
| shf_carry | input | 1 | Carry-out of the shifter |
| op_code | input | 4 | Operation selector |
| set_flags | input | 1 | Request to update the condition flags |
| dst_idx | input | 4 | Destination register index |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Operation result |
| result_we | output | 1 | Result write strobe |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| flags_we | output | 1 | Flag write strobe |
| restore_mode | output | 1 | Request to restore the saved processor mode |

## Verification
The bench instantiates the unit with its default parameters: a 32-bit datapath, a 4-bit register index and register 15 as the program counter. At this width, the directed cases can reach the sign boundaries 0x7FFFFFFF and 0x80000000, the all-ones operands, and zero results from both arithmetic and bitwise selectors. Random operands cover every selector under all sixteen incoming flag combinations, with set-flags and destination indices varied. This lets the carry-input forms, the reversed subtracts and the program-counter restore case be exercised alongside one another.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'h0, OP_XOR  = 4'h1, OP_SUB  = 4'h2, OP_RSB  = 4'h3,
    OP_ADD  = 4'h4, OP_ADC  = 4'h5, OP_SBC  = 4'h6, OP_RSC  = 4'h7,
    OP_TAND = 4'h8, OP_TXOR = 4'h9, OP_CSUB = 4'hA, OP_CADD = 4'hB,
    OP_OR   = 4'hC, OP_MOVB = 4'hD, OP_CLR  = 4'hE, OP_NOTB = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic     arith;   // result comes from the adder
    logic     swap;    // B is the minuend
    logic     invert;  // subtract: add the complement
    cin_sel_e cin;     // carry input source
    logic     writes;  // result goes to the register file
  } ctl_t;

endpackage

// File: rtl/dpalu_decode.sv
module dpalu_decode
  import dpalu_pkg::*;
(
  input  logic [3:0] op_code,
  output ctl_t       ctl
);

  alu_op_e op;
  assign op = alu_op_e'(op_code);

  always_comb begin
    ctl        = '0;
    ctl.cin    = CIN_ZERO;
    ctl.writes = (op_code[3:2] != 2'b10);
    unique case (op)
      OP_SUB, OP_CSUB: begin ctl.arith = 1'b1; ctl.invert = 1'b1; ctl.cin = CIN_ONE;  end
      OP_RSB:          begin ctl.arith = 1'b1; ctl.invert = 1'b1; ctl.swap = 1'b1; ctl.cin = CIN_ONE; end
      OP_SBC:          begin ctl.arith = 1'b1; ctl.invert = 1'b1; ctl.cin = CIN_FLAG; end
      OP_RSC:          begin ctl.arith = 1'b1; ctl.invert = 1'b1; ctl.swap = 1'b1; ctl.cin = CIN_FLAG; end
      OP_ADD, OP_CADD: begin ctl.arith = 1'b1; ctl.cin = CIN_ZERO; end
      OP_ADC:          begin ctl.arith = 1'b1; ctl.cin = CIN_FLAG; end
      default:         ctl.arith = 1'b0;
    endcase
  end

endmodule

// File: rtl/dpalu_arith.sv
module dpalu_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         swap,
  input  logic         invert,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  localparam int MSB = W - 1;

  logic [W-1:0] x, y, yy;
  logic [W:0]   full;

  always_comb begin
    x    = swap ? opnd_b : opnd_a;
    y    = swap ? opnd_a : opnd_b;
    yy   = invert ? ~y : y;
    full = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, cin};
    sum  = full[MSB:0];
    cout = full[W];
    ovf  = (x[MSB] == yy[MSB]) && (sum[MSB] != x[MSB]);
  end

endmodule

// File: rtl/dpalu_logic.sv
module dpalu_logic
  import dpalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   op_code,
  output logic [W-1:0] lres
);

  alu_op_e op;
  assign op = alu_op_e'(op_code);

  always_comb begin
    unique case (op)
      OP_AND, OP_TAND: lres = opnd_a & opnd_b;
      OP_XOR, OP_TXOR: lres = opnd_a ^ opnd_b;
      OP_OR:           lres = opnd_a | opnd_b;
      OP_MOVB:         lres = opnd_b;
      OP_CLR:          lres = opnd_a & ~opnd_b;
      OP_NOTB:         lres = ~opnd_b;
      default:         lres = '0;
    endcase
  end

endmodule

// File: rtl/dpalu_flags.sv
module dpalu_flags
  import dpalu_pkg::*;
#(
  parameter int W      = 32,
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  ctl_t             ctl,
  input  logic [W-1:0]     result,
  input  logic             cout,
  input  logic             ovf,
  input  logic             shf_carry,
  input  logic             set_flags,
  input  logic [IDX_W-1:0] dst_idx,
  input  flags_t           flags_in,
  output flags_t           flags_out,
  output logic             flags_we,
  output logic             result_we,
  output logic             restore_mode
);

  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

  always_comb begin
    result_we    = ctl.writes;
    restore_mode = set_flags && ctl.writes && (dst_idx == PC_SEL);
    flags_we     = set_flags && !restore_mode;
    flags_out    = flags_in;
    if (flags_we) begin
      flags_out.n = result[W-1];
      flags_out.z = ~|result;
      if (ctl.arith) begin
        flags_out.c = cout;
        flags_out.v = ovf;
      end else begin
        flags_out.c = shf_carry;
      end
    end
  end

  always_comb begin
    // R8
    rst_nowr_chk: assert (!(restore_mode && !result_we));
    // R9
    zero_flag_chk: assert (!flags_we || (flags_out.z == (result == '0)));
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dpalu_pkg::*;
#(
  parameter int W      = 32,
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic             shf_carry,
  input  logic [3:0]       op_code,
  input  logic             set_flags,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [3:0]       flags_in,
  output logic [W-1:0]     result,
  output logic             result_we,
  output logic [3:0]       flags_out,
  output logic             flags_we,
  output logic             restore_mode
);

  ctl_t         ctl;
  flags_t       cur_fl, nxt_fl;
  logic [W-1:0] sum, lres;
  logic         cout, ovf, cin_bit;

  assign cur_fl    = flags_t'(flags_in);
  assign flags_out = nxt_fl;

  dpalu_decode u_dec (
    .op_code (op_code),
    .ctl     (ctl)
  );

  always_comb begin
    unique case (ctl.cin)
      CIN_ONE:  cin_bit = 1'b1;
      CIN_FLAG: cin_bit = cur_fl.c;
      default:  cin_bit = 1'b0;
    endcase
  end

  dpalu_arith #(.W(W)) u_arith (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .swap   (ctl.swap),
    .invert (ctl.invert),
    .cin    (cin_bit),
    .sum    (sum),
    .cout   (cout),
    .ovf    (ovf)
  );

  dpalu_logic #(.W(W)) u_logic (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .op_code (op_code),
    .lres    (lres)
  );

  assign result = ctl.arith ? sum : lres;

  dpalu_flags #(.W(W), .IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_flags (
    .ctl          (ctl),
    .result       (result),
    .cout         (cout),
    .ovf          (ovf),
    .shf_carry    (shf_carry),
    .set_flags    (set_flags),
    .dst_idx      (dst_idx),
    .flags_in     (cur_fl),
    .flags_out    (nxt_fl),
    .flags_we     (flags_we),
    .result_we    (result_we),
    .restore_mode (restore_mode)
  );

  logic is_bitwise;
  assign is_bitwise = (op_code[3:2] == 2'b11) || (!op_code[1] && (op_code[3:2] != 2'b01));

  always_comb begin
    // R2
    cmp_nowr_chk: assert (!((op_code[3:2] == 2'b10) && result_we));
    // R3
    sclr_hold_chk: assert (set_flags || (!flags_we && (flags_out == flags_in)));
    // R8
    rst_excl_chk: assert (!(restore_mode && flags_we));
    // R4
    logic_v_chk: assert (!is_bitwise || (flags_out[0] == flags_in[0]));
  end

endmodule

// File: tb/sim_dp_alu.sv
module sim_dp_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        sc_i = 1'b0, s_i = 1'b0;
  logic [3:0]  op_i = '0, rd_i = '0, fl_i = '0;
  logic [31:0] res_o;
  logic        we_o, fwe_o, rst_o;
  logic [3:0]  fl_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dp_alu u0 (
    .opnd_a (a_i), .opnd_b (b_i), .shf_carry (sc_i), .op_code (op_i),
    .set_flags (s_i), .dst_idx (rd_i), .flags_in (fl_i),
    .result (res_o), .result_we (we_o), .flags_out (fl_o),
    .flags_we (fwe_o), .restore_mode (rst_o)
  );

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [3:0]  fl;
    logic        fwe;
    logic        rst;
    logic [3:0]  op;
    logic        s;
  } exp_t;

  exp_t sb_q[$];

  // Reference built straight from the requirement text
  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                 input logic sc, input logic [3:0] op,
                                 input logic s, input logic [3:0] rd,
                                 input logic [3:0] fl);
    exp_t e;
    logic [32:0] t;
    logic [31:0] x, y, r;
    logic c, v, ar, ci, sub;
    ar = 1'b1; sub = 1'b0; ci = 1'b0; x = a; y = b; c = sc; v = fl[0];
    case (op)
      4'h0, 4'h8: begin ar = 0; r = a & b; end
      4'h1, 4'h9: begin ar = 0; r = a ^ b; end
      4'hC: begin ar = 0; r = a | b; end
      4'hD: begin ar = 0; r = b; end
      4'hE: begin ar = 0; r = a & ~b; end
      4'hF: begin ar = 0; r = ~b; end
      4'h2, 4'hA: begin sub = 1; ci = 1; end
      4'h3: begin sub = 1; ci = 1; x = b; y = a; end
      4'h6: begin sub = 1; ci = fl[1]; end
      4'h7: begin sub = 1; ci = fl[1]; x = b; y = a; end
      4'h5: ci = fl[1];
      default: ci = 1'b0;
    endcase
    if (ar) begin
      if (sub) begin
        r = x - y - 32'd1 + {31'd0, ci};
        c = ({1'b0, x} + {32'd0, ci}) > {1'b0, y};
        v = (x[31] != y[31]) && (r[31] != x[31]);
      end else begin
        t = {1'b0, x} + {1'b0, y} + {32'd0, ci};
        r = t[31:0];
        c = t[32];
        v = (x[31] == y[31]) && (r[31] != x[31]);
      end
    end
    e.res = r;
    e.we  = (op < 4'h8) || (op > 4'hB);
    e.rst = s && e.we && (rd == 4'hF);
    e.fwe = s && !e.rst;
    e.fl  = e.fwe ? {r[31], (r == 32'd0), c, v} : fl;
    e.op  = op;
    e.s   = s;
    return e;
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic sc,
                      input logic [3:0] op, input logic s, input logic [3:0] rd,
                      input logic [3:0] fl);
    @(posedge clk);
    #1;
    a_i = a; b_i = b; sc_i = sc; op_i = op; s_i = s; rd_i = rd; fl_i = fl;
    sb_q.push_back(model(a, b, sc, op, s, rd, fl));
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s op=%h act=%h exp=%h", tag, op_i, act, exp);
    end
  endtask

  function automatic bit arith_op(input logic [3:0] op);
    return (op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB});
  endfunction

  // Monitor: pop one expected item per cycle, compare mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        string ctag, vtag;
        e = sb_q.pop_front();
        chk("R1 result", res_o, e.res);
        chk("R2 result_we", {31'd0, we_o}, {31'd0, e.we});
        chk("R8 restore_mode", {31'd0, rst_o}, {31'd0, e.rst});
        chk(e.s ? "R8 flags_we" : "R3 flags_we", {31'd0, fwe_o}, {31'd0, e.fwe});
        if (!e.fwe) begin
          chk(e.s ? "R8 flags_hold" : "R3 flags_hold", {28'd0, fl_o}, {28'd0, e.fl});
        end else begin
          chk("R9 n_z", {30'd0, fl_o[3:2]}, {30'd0, e.fl[3:2]});
          if (!arith_op(e.op)) begin
            ctag = "R4 c"; vtag = "R4 v";
          end else begin
            ctag = (e.op inside {4'h4, 4'h5, 4'hB}) ? "R6 c" : "R5 c";
            vtag = "R7 v";
          end
          chk(ctag, {31'd0, fl_o[1]}, {31'd0, e.fl[1]});
          chk(vtag, {31'd0, fl_o[0]}, {31'd0, e.fl[0]});
        end
      end
    end
  end

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired, queue=%0d", sb_q.size());
      finish_up();
    end
  end

  initial begin
    // idle state with all inputs zero: bitwise AND, no flag request
    #1;
    chk("R3 idle flags_we", {31'd0, fwe_o}, 32'd0);
    chk("R2 idle result_we", {31'd0, we_o}, 32'd1);
    chk("R8 idle restore", {31'd0, rst_o}, 32'd0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R6/R7 signed overflow on add
    send(32'h7FFF_FFFF, 32'h1, 1'b0, 4'h4, 1'b1, 4'h0, 4'h0);
    // R6 carry out, zero result
    send(32'hFFFF_FFFF, 32'h1, 1'b0, 4'h4, 1'b1, 4'h1, 4'h0);
    // R6 carry input from flag
    send(32'hFFFF_FFFE, 32'h1, 1'b0, 4'h5, 1'b1, 4'h2, 4'b0010);
    // R5 no borrow on equal operands
    send(32'h0, 32'h0, 1'b0, 4'h2, 1'b1, 4'h3, 4'h0);
    // R5 borrow
    send(32'h0, 32'h1, 1'b0, 4'hA, 1'b1, 4'h3, 4'b0010);
    // R7 subtract overflow
    send(32'h8000_0000, 32'h1, 1'b0, 4'h2, 1'b1, 4'h4, 4'h0);
    // R5 reversed with carry input clear and set
    send(32'h5, 32'h3, 1'b0, 4'h7, 1'b1, 4'h5, 4'h0);
    send(32'h5, 32'h9, 1'b0, 4'h7, 1'b1, 4'h5, 4'b0010);
    send(32'h1, 32'h1, 1'b0, 4'h6, 1'b1, 4'h5, 4'h0);
    // R4 bitwise takes shifter carry, keeps V
    send(32'hF0F0_0000, 32'h0F0F_0000, 1'b1, 4'h0, 1'b1, 4'h6, 4'b0001);
    send(32'h0, 32'h0, 1'b0, 4'hF, 1'b1, 4'h6, 4'b0011);
    // R8 restore on PC destination
    send(32'h1234, 32'h8000_0000, 1'b1, 4'hD, 1'b1, 4'hF, 4'b0101);
    // R8 compare to PC: no restore, flags update
    send(32'h3, 32'h3, 1'b0, 4'hA, 1'b1, 4'hF, 4'b1000);
    // R3 PC destination without flag request
    send(32'h3, 32'h2, 1'b1, 4'h4, 1'b0, 4'hF, 4'b1111);

    // every selector under every incoming flag combination
    for (int op = 0; op < 16; op++) begin
      for (int f = 0; f < 16; f++) begin
        repeat (4) begin
          send($urandom, $urandom, 1'($urandom), 4'(op), 1'($urandom),
               4'($urandom), 4'(f));
        end
      end
    end

    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    finish_up();
  end

endmodule